// File: doc/BRIEF.md
# Programmable Pin Lookup Logic

This block sits beside a bank of general-purpose pins. The pins are split into groups of five. Each group either stays plain GPIO or becomes a small lookup function of its own low pins. In lookup form, a truth table held in a register picks the level of one or two higher pins of the same group. No host action is needed once the tables and mode are written.

The block takes the raw pin levels and passes them through a synchroniser. It then computes the lookup result and registers it. It presents two outputs to the pad logic. One is an output value per pin. The other is a per-pin override mask, which tells the GPIO data path to drive that pin from the lookup value instead of from its own direction and data registers. Configuration is written over a simple write-only register port.

Register map (8-bit data):
- Address 0 is the mode register, with 2 bits per group; group g uses bits [2g+1:2g].
- Address 1+2g holds table A of group g.
- Address 2+2g holds table B of group g.

Mode codes:
- 00 is plain GPIO.
- 01 is two inputs to one output.
- 10 is three inputs to one output.
- 11 is three inputs to two outputs.

Within group g, local pin k is bank pin 5g+k. The table index uses local pin 0 as its least significant bit.

Top module: `pin_lut_bank`

## Requirements
- R1: After reset every mode field is 00 and every table is zero, with `lut_en` and `lut_out` all zero.
- R2: A group in mode 00 asserts no bit of `lut_en` and drives 0 on all five of its `lut_out` bits.
- R3: In mode 01, local pin 2 is the only overridden pin of the group. Its value is table A bit {pin1,pin0}, which selects from bits 3:0. Local pin 2's own input level has no effect.
- R4: With mode 01 and table A set to 8'h08, the output of local pin 2 is 1 only when local pins 0 and 1 are both 1.
- R5: In mode 10, local pin 3 is the only overridden pin. Its value is table A bit {pin2,pin1,pin0}.
- R6: In mode 11, local pins 3 and 4 are overridden. Pin 3 takes table A bit {pin2,pin1,pin0} and pin 4 takes table B bit {pin2,pin1,pin0}.
- R7: A change on `pin_in` appears on `lut_out` on the third rising clock edge after it: two synchroniser stages plus one output register.
- R8: A mode or table write sampled on a clock edge takes effect on `lut_en` and `lut_out` at the next edge. A group set back to 00 keeps its old mask for that one cycle and then releases all of its pins.
- R9: Writing one group's table or mode field changes only that group's outputs.
- R10: A write to an address above 2×NUM_GROUPS changes no output.
- R11: A `lut_out` bit can be 1 only where the same `lut_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| pin_in | input | 5×NUM_GROUPS | Raw pin levels, asynchronous |
| lut_out | output | 5×NUM_GROUPS | Lookup value per pin |
| lut_en | output | 5×NUM_GROUPS | Override mask, 1 where lookup drives the pin |

## Verification
The hardest situation to reach is the single cycle after a group is switched out of lookup mode. In that cycle the written mode is already in the register, but the mask and value still show the old function. The stimulus sets up a two-output function and settles the pins so that both outputs are 1. It then writes mode 00 and samples once before and once after the release edge. Latency is pinned down the same way: the bench changes the pins on a falling edge and samples on each of the next three cycles.

// File: rtl/pin_lut_pkg.sv
package pin_lut_pkg;
  localparam int GRP_W = 5;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    LM_GPIO = 2'b00,
    LM_2TO1 = 2'b01,
    LM_3TO1 = 2'b10,
    LM_3TO2 = 2'b11
  } lut_mode_e;

  // table index; the 2-input form keeps the top index bit at zero
  function automatic logic [2:0] lut_index(input logic [1:0] m, input logic [GRP_W-1:0] p);
    if (m == LM_2TO1) return {1'b0, p[1], p[0]};
    return p[2:0];
  endfunction

  // pins of a group that the lookup takes over
  function automatic logic [GRP_W-1:0] drive_mask(input logic [1:0] m);
    case (m)
      LM_2TO1: return 5'b00100;
      LM_3TO1: return 5'b01000;
      LM_3TO2: return 5'b11000;
      default: return 5'b00000;
    endcase
  endfunction

  // lookup values for a whole group, zero outside the mask
  function automatic logic [GRP_W-1:0] lut_values(input logic [1:0] m,
                                                  input logic [GRP_W-1:0] p,
                                                  input logic [REG_W-1:0] ta,
                                                  input logic [REG_W-1:0] tb);
    logic [2:0]       idx;
    logic [GRP_W-1:0] v;
    idx = lut_index(m, p);
    v   = '0;
    case (m)
      LM_2TO1: v[2] = ta[idx];
      LM_3TO1: v[3] = ta[idx];
      LM_3TO2: begin
        v[3] = ta[idx];
        v[4] = tb[idx];
      end
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pin_lut_sync.sv
module pin_lut_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pin_lut_cfg.sv
module pin_lut_cfg
  import pin_lut_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int AW         = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [AW-1:0]                        addr,
  input  logic [REG_W-1:0]                     wdata,
  output logic [NUM_GROUPS-1:0][1:0]           mode,
  output logic [NUM_GROUPS-1:0][REG_W-1:0]     tab_a,
  output logic [NUM_GROUPS-1:0][REG_W-1:0]     tab_b
);
  localparam logic [AW-1:0] MODE_ADDR = '0;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [AW-1:0] A_ADDR = AW'(1 + 2*g);
    localparam logic [AW-1:0] B_ADDR = AW'(2 + 2*g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode[g]  <= LM_GPIO;
        tab_a[g] <= '0;
        tab_b[g] <= '0;
      end else if (we) begin
        if (addr == MODE_ADDR) mode[g]  <= wdata[2*g +: 2];
        if (addr == A_ADDR)    tab_a[g] <= wdata;
        if (addr == B_ADDR)    tab_b[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/pin_lut_group.sv
module pin_lut_group
  import pin_lut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [REG_W-1:0] tab_a,
  input  logic [REG_W-1:0] tab_b,
  input  logic [GRP_W-1:0] pins,
  output logic [GRP_W-1:0] val_q,
  output logic [GRP_W-1:0] en_q
);
  logic [GRP_W-1:0] val_d;
  logic [GRP_W-1:0] en_d;

  assign val_d = lut_values(mode, pins, tab_a, tab_b);
  assign en_d  = drive_mask(mode);

  // value and mask share one register stage so they never disagree
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      en_q  <= '0;
    end else begin
      val_q <= val_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/pin_lut_bank.sv
module pin_lut_bank
  import pin_lut_pkg::*;
#(
  parameter int NUM_GROUPS  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 4,
  localparam int PINS       = GRP_W * NUM_GROUPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  lut_out,
  output logic [PINS-1:0]  lut_en
);
  // named internal wires, also seen by the checker
  logic [PINS-1:0]                     sync_pins;
  logic [NUM_GROUPS-1:0][1:0]          cfg_mode;
  logic [NUM_GROUPS-1:0][REG_W-1:0]    cfg_tab_a;
  logic [NUM_GROUPS-1:0][REG_W-1:0]    cfg_tab_b;

  pin_lut_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (sync_pins)
  );

  pin_lut_cfg #(.NUM_GROUPS(NUM_GROUPS), .AW(AW)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .mode (cfg_mode),
    .tab_a(cfg_tab_a),
    .tab_b(cfg_tab_b)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lut
    pin_lut_group u_grp (
      .clk  (clk),
      .rst_n(rst_n),
      .mode (cfg_mode[g]),
      .tab_a(cfg_tab_a[g]),
      .tab_b(cfg_tab_b[g]),
      .pins (sync_pins[GRP_W*g +: GRP_W]),
      .val_q(lut_out[GRP_W*g +: GRP_W]),
      .en_q (lut_en[GRP_W*g +: GRP_W])
    );
  end
endmodule

// File: rtl/pin_lut_bank_chk.sv
module pin_lut_bank_chk
  import pin_lut_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  localparam int PINS      = GRP_W * NUM_GROUPS
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_GROUPS-1:0][1:0]        mode,
  input logic [NUM_GROUPS-1:0][REG_W-1:0]  tab_a,
  input logic [NUM_GROUPS-1:0][REG_W-1:0]  tab_b,
  input logic [PINS-1:0]                   sync_pins,
  input logic [PINS-1:0]                   lut_out,
  input logic [PINS-1:0]                   lut_en
);
  a_r11_out_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_out & ~lut_en) == '0);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    localparam int B = GRP_W * g;

    // R2 and R8: plain mode releases every pin of the group
    a_r2_gpio_no_override: assert property (@(posedge clk) disable iff (!rst_n)
      mode[g] == 2'b00 |=> lut_en[B +: GRP_W] == '0);

    a_r3_pair_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      mode[g] == 2'b01 |=> (lut_en[B +: GRP_W] == 5'b00100) &&
        (lut_out[B+2] == $past(tab_a[g][{sync_pins[B+1], sync_pins[B]}])));

    a_r5_triple_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      mode[g] == 2'b10 |=> (lut_en[B +: GRP_W] == 5'b01000) &&
        (lut_out[B+3] == $past(tab_a[g][sync_pins[B +: 3]])));

    a_r6_dual_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      mode[g] == 2'b11 |=> (lut_en[B +: GRP_W] == 5'b11000) &&
        (lut_out[B+3] == $past(tab_a[g][sync_pins[B +: 3]])) &&
        (lut_out[B+4] == $past(tab_b[g][sync_pins[B +: 3]])));
  end
endmodule

bind pin_lut_bank pin_lut_bank_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (cfg_mode),
  .tab_a    (cfg_tab_a),
  .tab_b    (cfg_tab_b),
  .sync_pins(sync_pins),
  .lut_out  (lut_out),
  .lut_en   (lut_en)
);

// File: tb/pin_lut_bank_test.sv
module pin_lut_bank_test;
  localparam int NG   = 2;
  localparam int PINS = 5 * NG;
  localparam int AW   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            we;
  logic [AW-1:0]   addr;
  logic [7:0]      wdata;
  logic [PINS-1:0] pins;
  wire  [PINS-1:0] out;
  wire  [PINS-1:0] en;

  int total = 0;
  int bad   = 0;

  logic [1:0] m_mode [NG];
  logic [7:0] m_ta   [NG];
  logic [7:0] m_tb   [NG];

  pin_lut_bank #(.NUM_GROUPS(NG), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .pin_in(pins), .lut_out(out), .lut_en(en)
  );

  function automatic logic [PINS-1:0] exp_en();
    logic [PINS-1:0] e = '0;
    for (int g = 0; g < NG; g++) begin
      if (m_mode[g] == 2'd1) e[5*g+2] = 1'b1;
      if (m_mode[g] >= 2'd2) e[5*g+3] = 1'b1;
      if (m_mode[g] == 2'd3) e[5*g+4] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [PINS-1:0] exp_out(logic [PINS-1:0] p);
    logic [PINS-1:0] o = '0;
    for (int g = 0; g < NG; g++) begin
      int b  = 5 * g;
      int i2 = int'(p[b]) + 2 * int'(p[b+1]);
      int i3 = i2 + 4 * int'(p[b+2]);
      if (m_mode[g] == 2'd1) o[b+2] = m_ta[g][i2];
      if (m_mode[g] >= 2'd2) o[b+3] = m_ta[g][i3];
      if (m_mode[g] == 2'd3) o[b+4] = m_tb[g][i3];
    end
    return o;
  endfunction

  task automatic chk(string tag, logic [PINS-1:0] got, logic [PINS-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic check_now(string tag);
    chk({tag, " out"}, out, exp_out(pins));
    chk({tag, " en"},  en,  exp_en());
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 0) begin
      for (int g = 0; g < NG; g++) m_mode[g] = d[2*g +: 2];
    end else if (a <= 2 * NG) begin
      if (a % 2 == 1) m_ta[(a - 1) / 2] = d;
      else            m_tb[(a - 2) / 2] = d;
    end
  endtask

  task automatic set_mode(int g, logic [1:0] m);
    logic [7:0] d = '0;
    for (int k = 0; k < NG; k++) d[2*k +: 2] = (k == g) ? m : m_mode[k];
    wr('0, d);
  endtask

  task automatic apply(logic [PINS-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset en", en, '0);
    chk("R1 reset out", out, '0);
  endtask

  task automatic t_gpio();
    apply('1);
    check_now("R2 gpio all ones");
    apply(10'b10101_01010);
    check_now("R2 gpio pattern");
  endtask

  task automatic t_and();
    wr(4'd1, 8'h08);
    set_mode(0, 2'b01);
    for (int i = 0; i < 8; i++) begin
      apply(PINS'(i) | 10'b00000_11000);   // upper pins set, must not matter
      check_now("R4 and table");
      chk("R4 and value", PINS'(out[2]), PINS'(i[1:0] == 2'b11));
    end
  endtask

  task automatic t_xor();
    wr(4'd1, 8'hF6);                        // bits 7:4 outside a 2-input table
    for (int i = 0; i < 8; i++) begin
      apply(PINS'(i));                      // pin 2 toggles too: R3 ignores it
      check_now("R3 two-input xor");
    end
  endtask

  task automatic t_3to1();
    wr(4'd3, 8'hE8);
    set_mode(1, 2'b10);
    for (int i = 0; i < 8; i++) begin
      apply(PINS'(i) << 5);
      check_now("R5 three-input majority");   // also R11 via full vector
    end
  endtask

  task automatic t_3to2();
    wr(4'd1, 8'h96);
    wr(4'd2, 8'hE8);
    set_mode(0, 2'b11);
    for (int i = 0; i < 8; i++) begin
      apply(PINS'(i) | 10'b10110_00000);
      check_now("R6 adder sum/carry");
      chk("R11 masked zero", out & ~en, '0);
    end
  endtask

  task automatic t_latency();
    wr(4'd1, 8'h08);
    set_mode(0, 2'b01);
    apply('0);
    @(negedge clk);
    pins = 10'b00000_00011;
    @(negedge clk);
    chk("R7 after edge 1", PINS'(out[2]), '0);
    @(negedge clk);
    chk("R7 after edge 2", PINS'(out[2]), '0);
    @(negedge clk);
    chk("R7 after edge 3", PINS'(out[2]), PINS'(1));
  endtask

  task automatic t_release();
    wr(4'd1, 8'h96);
    wr(4'd2, 8'hE8);
    set_mode(0, 2'b11);
    apply(10'b00000_00111);
    chk("R8 before release", out & 10'h1F, 10'b00000_11000);
    set_mode(0, 2'b00);
    chk("R8 mask held one cycle", en & 10'h1F, 10'b00000_11000);
    @(negedge clk);
    chk("R8 mask released", en & 10'h1F, '0);
    chk("R8 value cleared", out & 10'h1F, '0);
  endtask

  task automatic t_indep();
    wr(4'd1, 8'h08);
    wr(4'd3, 8'h0E);
    wr('0, 8'b0000_0101);
    apply(10'b00001_00001);
    check_now("R9 both groups");
    wr(4'd3, 8'h01);
    apply(10'b00001_00001);
    check_now("R9 after group1 table");
    apply(10'b00000_00011);
    check_now("R9 group0 untouched");
  endtask

  task automatic t_unmapped();
    wr(4'd9, 8'hFF);
    wr(4'd15, 8'h00);
    @(negedge clk);
    check_now("R10 unmapped writes");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_mode[g] = 2'b00; m_ta[g] = '0; m_tb[g] = '0;
    end
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pins = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gpio();
    t_and();
    t_xor();
    t_3to1();
    t_3to2();
    t_latency();
    t_release();
    t_indep();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule